// File: doc/BRIEF.md
# Credit-Based Router Link

This block joins two on-chip network routers with a one-way flit channel governed by credits. The upstream half keeps a count of free slots in the downstream buffer. At reset that count equals the buffer depth. A flit may leave only while the count is above zero, and each departing flit uses up one slot. The downstream half stores arriving flits in a FIFO that its local consumer drains.

Slots that the consumer frees are not reported back one by one. They are gathered until a configurable block size is reached, and then a single credit message carrying that amount travels back up the return path. Both the flit path and the return path are register pipelines of configurable length, which stand in for wire delay between routers. A block size of one gives per-flit credits. Larger blocks send fewer control messages, but the upstream side waits longer before it can resume.

The local source and sink each see a plain valid/ready handshake. The link signals stay inside the block.

Top module: `credit_link`

## Requirements
- R1: After reset, `src_ready` is 1 and `snk_valid` is 0.
- R2: While the sink holds `snk_ready` at 0, the block accepts exactly DEPTH flits from the source and then holds `src_ready` at 0.
- R3: Each accepted flit consumes one credit. The credit count never exceeds DEPTH and never rises without freed slots coming back.
- R4: Flits reach `snk_data` in the order they were accepted, with their data unchanged.
- R5: Credits return only in units of BLOCK, and only after that many FIFO entries have been popped. Freeing fewer than BLOCK entries from a stalled state leaves `src_ready` at 0. Once a block returns, exactly BLOCK further flits are accepted.
- R6: If the pop that completes a block happens at clock edge E, `src_ready` is 0 through edge E+CRED_LAT and becomes 1 after edge E+CRED_LAT+1.
- R7: A flit accepted in the same cycle that a credit message arrives changes the count by the net amount (BLOCK minus one). After any amount of traffic has drained, the count is back at DEPTH.
- R8: The FIFO is never written while it holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source offers a flit |
| src_data | input | DATA_W | Flit from the source |
| src_ready | output | 1 | At least one credit is held; the flit is taken when `src_valid` is also 1 |
| snk_valid | output | 1 | FIFO holds a flit for the sink |
| snk_data | output | DATA_W | Flit at the FIFO head |
| snk_ready | input | 1 | Sink takes the head flit |

## Verification
The bench fills the FIFO against a stalled sink and expects the intake to stop at exactly the buffer depth. A counter that started at the wrong value, or that skipped a decrement, would accept one flit too many or too few. It then frees a single slot and checks that nothing restarts. A design that sent credits per flit instead of per block would reopen the source early. It frees the second slot and checks the exact cycle in which `src_ready` rises, which catches a missing or extra stage on the return path. Last, a long stream runs with a sink that drains in an irregular pattern, so sends and credit arrivals land in the same cycle. A design that lost the net update would come back with fewer than DEPTH credits once everything had drained.

// File: rtl/clink_pkg.sv
package clink_pkg;

  // New credit level after one cycle: a flit taken costs one,
  // an arriving credit message adds its amount.
  function automatic int credit_update(int level, logic took, logic back, int amount);
    return level - (took ? 1 : 0) + (back ? amount : 0);
  endfunction

  // Circular pointer advance over a buffer of the given depth.
  function automatic int wrap_inc(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Freed slots waiting to be returned, including this cycle's pop.
  function automatic int freed_total(int held, logic popped);
    return held + (popped ? 1 : 0);
  endfunction

  // Occupancy after a push and/or pop.
  function automatic int occ_update(int occ, logic pushed, logic popped);
    return occ + (pushed ? 1 : 0) - (popped ? 1 : 0);
  endfunction

endpackage

// File: rtl/clink_pipe.sv
module clink_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [STAGES-1:0] stage_v;
  logic [W-1:0]      stage_d [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_v[0] <= 1'b0;
          stage_d[0] <= '0;
        end else begin
          stage_v[0] <= in_valid;
          stage_d[0] <= in_data;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_v[i] <= 1'b0;
          stage_d[i] <= '0;
        end else begin
          stage_v[i] <= stage_v[i-1];
          stage_d[i] <= stage_d[i-1];
        end
      end
    end
  end

  assign out_valid = stage_v[STAGES-1];
  assign out_data  = stage_d[STAGES-1];

endmodule

// File: rtl/clink_sender.sv
module clink_sender
  import clink_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              cred_valid,
  input  logic [CNT_W-1:0]  cred_amt,
  output logic              flit_valid,
  output logic [DATA_W-1:0] flit_data
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] level_q;
  logic             take;
  int               level_next_i;

  assign src_ready    = (level_q != '0);
  assign take         = src_valid && src_ready;
  assign level_next_i = credit_update(int'(level_q), take, cred_valid, int'(cred_amt));

  assign flit_valid = take;
  assign flit_data  = src_data;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= FULL;
    else        level_q <= CNT_W'(level_next_i);
  end

  // R3: the count must never climb above the buffer depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level_next_i <= DEPTH);

  // R3: the count only rises when a credit message arrives
  assert_rise_needs_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cred_valid |=> level_q <= $past(level_q));

endmodule

// File: rtl/clink_receiver.sv
module clink_receiver
  import clink_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int BLOCK  = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid,
  input  logic [DATA_W-1:0] flit_data,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready,
  output logic              cred_valid,
  output logic [CNT_W-1:0]  cred_amt
);

  localparam int               PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] BLK   = CNT_W'(BLOCK);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  occ_q;
  logic [CNT_W-1:0]  held_q;
  logic [CNT_W-1:0]  freed;
  logic              pop, emit, cred_q;

  assign snk_valid = (occ_q != '0);
  assign snk_data  = mem[rd_ptr];
  assign pop       = snk_valid && snk_ready;

  // FIFO storage and pointers
  always_ff @(posedge clk) begin
    if (flit_valid) mem[wr_ptr] <= flit_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (flit_valid) wr_ptr <= PTR_W'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)        rd_ptr <= PTR_W'(wrap_inc(int'(rd_ptr), DEPTH));
      occ_q <= CNT_W'(occ_update(int'(occ_q), flit_valid, pop));
    end
  end

  // Block credit accumulator
  assign freed = CNT_W'(freed_total(int'(held_q), pop));
  assign emit  = (freed >= BLK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      cred_q <= 1'b0;
    end else begin
      held_q <= emit ? (freed - BLK) : freed;
      cred_q <= emit;
    end
  end

  assign cred_valid = cred_q;
  assign cred_amt   = BLK;

  // R8: the link must never deliver into a full buffer
  assert_fifo_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> occ_q < FULL);

  // R5: fewer than a block of freed slots may be held back
  assert_block_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    held_q < BLK);

  // R5: a credit message follows a real pop in the cycle before
  assert_credit_after_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cred_q) |-> $past(pop));

endmodule

// File: rtl/credit_link.sv
module credit_link #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int BLOCK    = 2,
  parameter int FLIT_LAT = 1,
  parameter int CRED_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              tx_valid, rx_valid;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic              crd_tx_valid, crd_rx_valid;
  logic [CNT_W-1:0]  crd_tx_amt, crd_rx_amt;

  clink_sender #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_send (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .src_ready  (src_ready),
    .cred_valid (crd_rx_valid),
    .cred_amt   (crd_rx_amt),
    .flit_valid (tx_valid),
    .flit_data  (tx_data)
  );

  clink_pipe #(.W(DATA_W), .STAGES(FLIT_LAT)) u_flit_wire (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .out_valid (rx_valid),
    .out_data  (rx_data)
  );

  clink_receiver #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BLOCK(BLOCK), .CNT_W(CNT_W)) u_recv (
    .clk        (clk),
    .rst_n      (rst_n),
    .flit_valid (rx_valid),
    .flit_data  (rx_data),
    .snk_valid  (snk_valid),
    .snk_data   (snk_data),
    .snk_ready  (snk_ready),
    .cred_valid (crd_tx_valid),
    .cred_amt   (crd_tx_amt)
  );

  clink_pipe #(.W(CNT_W), .STAGES(CRED_LAT)) u_credit_wire (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (crd_tx_valid),
    .in_data   (crd_tx_amt),
    .out_valid (crd_rx_valid),
    .out_data  (crd_rx_amt)
  );

endmodule

// File: tb/credit_link_test.sv
`timescale 1ns/1ps
module credit_link_test;

  localparam int DATA_W   = 16;
  localparam int DEPTH    = 8;
  localparam int BLOCK    = 2;
  localparam int FLIT_LAT = 1;
  localparam int CRED_LAT = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic              src_ready;
  logic              snk_valid;
  logic [DATA_W-1:0] snk_data;
  logic              snk_ready = 1'b0;
  logic              sink_auto = 1'b0;
  logic [7:0]        lfsr = 8'hA5;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [DATA_W-1:0] expq [$];
  logic [DATA_W-1:0] next_word = 16'h1000;

  credit_link #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BLOCK(BLOCK),
                .FLIT_LAT(FLIT_LAT), .CRED_LAT(CRED_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .snk_valid(snk_valid), .snk_data(snk_data),
    .snk_ready(snk_ready)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Monitor: pops the scoreboard on each sink handshake (R4)
  always @(negedge clk) begin
    if (rst_n && snk_valid && snk_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected flit", int'(snk_data), -1);
      end else begin
        logic [DATA_W-1:0] want;
        want = expq.pop_front();
        check(snk_data == want, "R4 order/data", int'(snk_data), int'(want));
      end
    end
  end

  // Irregular sink pattern for the streaming phase
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (sink_auto) #1 snk_ready = lfsr[0] | lfsr[2];
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Driver: offers one flit for one cycle, records it if accepted
  task automatic offer(input bit v, output bit acc);
    src_valid = v;
    src_data  = next_word;
    @(negedge clk);
    acc = v && src_ready;
    if (acc) begin
      expq.push_back(next_word);
      next_word = next_word + 16'h0013;
    end
    @(posedge clk); #1;
    src_valid = 1'b0;
  endtask

  task automatic fill_count(input int tries, output int n);
    bit acc;
    n = 0;
    for (int i = 0; i < tries; i++) begin
      offer(1'b1, acc);
      if (acc) n++;
    end
  endtask

  task automatic drain();
    snk_ready = 1'b1;
    for (int i = 0; i < 400 && (expq.size() != 0 || snk_valid); i++) tick();
    snk_ready = 1'b0;
    check(expq.size() == 0, "R4 drain complete", expq.size(), 0);
  endtask

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check(src_ready == 1'b1, "R1 src_ready after reset", int'(src_ready), 1);
    check(snk_valid == 1'b0, "R1 snk_valid after reset", int'(snk_valid), 0);
    tick();

    // R2: stalled sink, intake stops at DEPTH
    fill_count(DEPTH + 4, n);
    check(n == DEPTH, "R2 flits accepted while stalled", n, DEPTH);
    repeat (CRED_LAT + 4) tick();
    @(negedge clk);
    check(src_ready == 1'b0, "R3 no credit without pops", int'(src_ready), 0);
    check(snk_valid == 1'b1, "R2 buffer holds flits", int'(snk_valid), 1);
    tick();

    // R5: one pop is less than a block
    snk_ready = 1'b1; tick(); snk_ready = 1'b0;
    repeat (CRED_LAT + 5) tick();
    @(negedge clk);
    check(src_ready == 1'b0, "R5 partial block returns nothing", int'(src_ready), 0);
    tick();

    // R6: second pop completes the block at edge E
    snk_ready = 1'b1;
    @(posedge clk); #1;
    snk_ready = 1'b0;
    for (int k = 0; k <= CRED_LAT + 1; k++) begin
      @(negedge clk);
      check(src_ready == (k == CRED_LAT + 1), "R6 restart timing",
            int'(src_ready), (k == CRED_LAT + 1) ? 1 : 0);
      @(posedge clk); #1;
    end

    // R5: exactly one block of new flits fits
    fill_count(BLOCK + 3, n);
    check(n == BLOCK, "R5 flits after one block", n, BLOCK);

    drain();

    // R7: streaming with irregular sink, sends and credits overlap
    sink_auto = 1'b1;
    for (int i = 0; i < 60; i++) begin
      bit acc;
      acc = 1'b0;
      for (int t = 0; t < 50 && !acc; t++) offer(1'b1, acc);
    end
    sink_auto = 1'b0;
    #1;
    drain();
    repeat (CRED_LAT + 6) tick();
    fill_count(DEPTH + 4, n);
    check(n == DEPTH, "R7 credits restored after stream", n, DEPTH);
    check(n <= DEPTH, "R8 no write beyond depth", n, DEPTH);

    drain();
    repeat (CRED_LAT + 6) tick();
    @(negedge clk);
    check(src_ready == 1'b1, "R3 idle with full credit", int'(src_ready), 1);
    check(snk_valid == 1'b0, "R4 sink empty at end", int'(snk_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule